// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Engine

This block multiplies two matrices of signed N-bit integers on a K×K grid of multiply-accumulate cells. Every cycle that `in_valid` is high is one step of the inner dimension. On a step, `a_vec` carries one column of the left matrix, with lane i holding row i. `b_vec` carries one row of the right matrix, with lane j holding column j. Inside the block, lane i of `a_vec` and lane j of `b_vec` are delayed by i and j cycles. The delayed `a` operands sweep across the rows and the delayed `b` operands sweep down the columns, so that matching operands meet in cell (i,j) after i+j cycles. Each cell keeps its own 4N-bit partial sum, so the result stays in place while the operands move past it.

Three controls travel with each step. The keep flag either adds the step's product to the current partial sums or starts a new sum from that product. The final flag marks the last step of a job. A separate clear input zeroes every partial sum. When a final step has passed through a cell, the cell copies its sum into a result register. The block then emits the K result rows one per cycle as K-lane vectors of untruncated 4N-bit signed values. Each row is tagged with its index. For a K-step job the last row leaves 3K−2 cycles after the first step.

Top module: `sysmat_engine`

## Requirements
- R1: After reset, and until the first final step has drained, `out_valid` is low and `out_vec` is all zero.
- R2: Result element (i,j) is the signed sum, over the job's steps, of a-lane i times b-lane j. Lane i of `a_vec` and `b_vec` sits at bits [i*N +: N]. Products are sign-extended into a 4N-bit sum.
- R3: With OUT_REG=0, row i of a job is presented exactly K+i cycles after the cycle that carried its final step. OUT_REG=1 adds one cycle. A K-step job therefore shows its last row 3K−2 cycles after its first step.
- R4: Rows leave one per cycle in the order 0 to K−1, with `out_row` equal to the row index. Column j sits in `out_vec` bits [j*4N +: 4N].
- R5: A step with keep high adds its products to the current partial sums. This includes sums left over from an earlier job.
- R6: A step with keep low discards the partial sums and starts each sum at that step's product.
- R7: `ctl_clear` zeroes every partial sum at the next edge. Results already captured are not affected. Clear must not coincide with a step.
- R8: Operands at the most negative value give exact products with no truncation. For example, K steps of (−2^(N−1))·(−2^(N−1)) yield K·2^(2N−2).
- R9: Outside a drain, `out_valid` is low and `out_vec` is zero. Data on the operand lanes in cycles with `in_valid` low has no effect on any result.
- R10: Final steps may follow each other every K cycles. In that case a new job's steps do not corrupt the drain of the previous job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The current cycle carries one step |
| ctl_keep | input | 1 | 1: add to partial sums; 0: restart sums from this step |
| ctl_final | input | 1 | This step is the last of the job |
| ctl_clear | input | 1 | Zero all partial sums at the next edge |
| a_vec | input | K*N | Left-operand column, lane i = row i |
| b_vec | input | K*N | Right-operand row, lane j = column j |
| out_valid | output | 1 | A result row is presented |
| out_row | output | RW | Index of the presented row |
| out_vec | output | K*4N | Result row, lane j = column j |

## Verification
The checker assumes that the surrounding logic never raises clear in a step cycle. It also assumes that final steps are at least K cycles apart. Under those two assumptions the drain timing and the contiguous row order are fixed properties of the block. The stimulus respects both rules: clear pulses are issued only after the array has drained, and jobs of K or more steps are issued back to back, while a shorter job is followed by idle cycles. Idle cycles carry random operand data so that the bench can show that data without `in_valid` does not affect any result.

// File: rtl/sysmat_pkg.sv
package sysmat_pkg;

   // Control that travels with one step through the array
   typedef struct packed {
      logic vld;
      logic keep;
      logic last;
   } step_tag_t;

   localparam int TAG_W = $bits(step_tag_t);

endpackage

// File: rtl/sysmat_tapline.sv
// Delay line with TAPS consecutive taps starting at delay FIRST.
module sysmat_tapline #(
   parameter int W     = 8,
   parameter int FIRST = 0,
   parameter int TAPS  = 4,
   localparam int DEPTH = FIRST + TAPS - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      din,
   output logic [TAPS*W-1:0] taps
);

   if (TAPS < 1 || FIRST < 0 || DEPTH < 1) begin : g_bad_cfg
      $error("sysmat_tapline: needs TAPS>=1, FIRST>=0 and at least one stage");
   end

   logic [W-1:0] stage [DEPTH+1];

   assign stage[0] = din;

   for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage[s] <= '0;
         else        stage[s] <= stage[s-1];
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign taps[k*W +: W] = stage[FIRST+k];
   end

endmodule

// File: rtl/sysmat_pe.sv
// One multiply-accumulate cell holding a running sum and a captured result.
module sysmat_pe
   import sysmat_pkg::*;
#(
   parameter int N     = 8,
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  step_tag_t        tag,
   input  logic [N-1:0]     a,
   input  logic [N-1:0]     b,
   output logic [ACC_W-1:0] res
);

   if (ACC_W <= 2*N) begin : g_bad_cfg
      $error("sysmat_pe: accumulator must be wider than a product");
   end

   logic signed [2*N-1:0]   prod;
   logic signed [ACC_W-1:0] prod_ext;
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] base;
   logic signed [ACC_W-1:0] sum;

   assign prod     = $signed(a) * $signed(b);
   assign prod_ext = {{(ACC_W-2*N){prod[2*N-1]}}, prod};
   assign base     = tag.keep ? acc : '0;
   assign sum      = base + prod_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         res <= '0;
      end else begin
         if (clear)        acc <= '0;
         else if (tag.vld) acc <= sum;
         if (tag.vld && tag.last) res <= sum;
      end
   end

endmodule

// File: rtl/sysmat_drain.sv
// Presents one finished result row per cycle.
module sysmat_drain #(
   parameter int K       = 4,
   parameter int ACC_W   = 32,
   parameter int OUT_REG = 0,
   parameter int RW      = 2,
   localparam int ROW_W  = K * ACC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [K-1:0]       fin,
   input  logic [K*ROW_W-1:0] res_flat,
   output logic               out_valid,
   output logic [RW-1:0]      out_row,
   output logic [ROW_W-1:0]   out_vec
);

   logic [K-1:0]     row_done;
   logic             sel_valid;
   logic [RW-1:0]    sel_row;
   logic [ROW_W-1:0] sel_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) row_done <= '0;
      else        row_done <= fin;
   end

   always_comb begin
      sel_row = '0;
      sel_vec = '0;
      for (int r = 0; r < K; r++) begin
         if (row_done[r]) begin
            sel_row = sel_row | RW'(r);
            sel_vec = sel_vec | res_flat[r*ROW_W +: ROW_W];
         end
      end
      sel_valid = |row_done;
   end

   if (OUT_REG == 1) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_vec   <= '0;
         end else begin
            out_valid <= sel_valid;
            out_row   <= sel_row;
            out_vec   <= sel_vec;
         end
      end
   end else begin : g_out_comb
      assign out_valid = sel_valid;
      assign out_row   = sel_row;
      assign out_vec   = sel_vec;
   end

endmodule

// File: rtl/sysmat_engine.sv
module sysmat_engine
   import sysmat_pkg::*;
#(
   parameter int K       = 4,
   parameter int N       = 8,
   parameter int OUT_REG = 0,
   localparam int ACC_W  = 4 * N,
   localparam int RW     = (K > 1) ? $clog2(K) : 1,
   localparam int TW     = TAG_W + N
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               ctl_keep,
   input  logic               ctl_final,
   input  logic               ctl_clear,
   input  logic [K*N-1:0]     a_vec,
   input  logic [K*N-1:0]     b_vec,
   output logic               out_valid,
   output logic [RW-1:0]      out_row,
   output logic [K*ACC_W-1:0] out_vec
);

   if (K < 2)                        begin : g_bad_k   $error("sysmat_engine: K must be at least 2"); end
   if (N < 2)                        begin : g_bad_n   $error("sysmat_engine: N must be at least 2"); end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg $error("sysmat_engine: OUT_REG must be 0 or 1"); end

   step_tag_t                  in_tag;
   logic [K*TW-1:0]            a_taps [K];
   logic [K*N-1:0]             b_taps [K];
   logic [K*K*ACC_W-1:0]       res_flat;
   logic [K-1:0]               fin;

   assign in_tag = '{vld: in_valid, keep: ctl_keep, last: ctl_final};

   // Row lanes: tag rides with the left operand
   for (genvar i = 0; i < K; i++) begin : g_a_line
      sysmat_tapline #(.W(TW), .FIRST(i), .TAPS(K)) u_line (
         .clk  (clk),
         .rst_n(rst_n),
         .din  ({in_tag, a_vec[i*N +: N]}),
         .taps (a_taps[i])
      );
   end

   // Column lanes
   for (genvar j = 0; j < K; j++) begin : g_b_line
      sysmat_tapline #(.W(N), .FIRST(j), .TAPS(K)) u_line (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (b_vec[j*N +: N]),
         .taps (b_taps[j])
      );
   end

   // Cell (i,j) sees both operands delayed by i+j cycles
   for (genvar i = 0; i < K; i++) begin : g_row
      for (genvar j = 0; j < K; j++) begin : g_col
         logic [TW-1:0] word;
         step_tag_t     tg;

         assign word = a_taps[i][j*TW +: TW];
         assign tg   = step_tag_t'(word[TW-1 -: TAG_W]);

         sysmat_pe #(.N(N), .ACC_W(ACC_W)) u_pe (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(ctl_clear),
            .tag  (tg),
            .a    (word[N-1:0]),
            .b    (b_taps[j][i*N +: N]),
            .res  (res_flat[(i*K+j)*ACC_W +: ACC_W])
         );

         if (j == K-1) begin : g_fin
            assign fin[i] = tg.vld & tg.last;
         end
      end
   end

   sysmat_drain #(.K(K), .ACC_W(ACC_W), .OUT_REG(OUT_REG), .RW(RW)) u_drain (
      .clk      (clk),
      .rst_n    (rst_n),
      .fin      (fin),
      .res_flat (res_flat),
      .out_valid(out_valid),
      .out_row  (out_row),
      .out_vec  (out_vec)
   );

endmodule

// File: rtl/sysmat_engine_chk.sv
module sysmat_engine_chk #(
   parameter int K       = 4,
   parameter int OUT_REG = 0,
   parameter int RW      = 2,
   parameter int ACC_W   = 32,
   localparam int SAT    = 2*K + 2,
   localparam int CW     = $clog2(SAT + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               ctl_final,
   input logic               ctl_clear,
   input logic               out_valid,
   input logic [RW-1:0]      out_row,
   input logic [K*ACC_W-1:0] out_vec
);

   // Cycles since the latest final step, saturating
   logic [CW-1:0] since;

   always_ff @(posedge clk) begin
      if (!rst_n)                    since <= CW'(SAT);
      else if (in_valid && ctl_final) since <= CW'(1);
      else if (since != CW'(SAT))    since <= since + CW'(1);
   end

   assert_clear_not_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clear |-> !in_valid);

   assert_final_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctl_final) |-> (since >= CW'(K)));

   assert_first_row_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_row == '0) |-> (since == CW'(K + OUT_REG)));

   assert_row_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_row) < K));

   assert_rows_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_row != RW'(K-1)) |=> (out_valid && out_row == RW'($past(out_row) + 1'b1)));

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_vec == '0));

endmodule

bind sysmat_engine sysmat_engine_chk #(
   .K(K), .OUT_REG(OUT_REG), .RW(RW), .ACC_W(ACC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .ctl_final(ctl_final),
   .ctl_clear(ctl_clear),
   .out_valid(out_valid),
   .out_row  (out_row),
   .out_vec  (out_vec)
);

// File: tb/sysmat_engine_bench.sv
`timescale 1ns/1ps
module sysmat_engine_bench;

   localparam int K       = 4;
   localparam int N       = 8;
   localparam int OUT_REG = 0;
   localparam int ACC_W   = 4 * N;
   localparam int RW      = 2;
   localparam int SLOTS   = 64;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               ctl_keep = 1'b0;
   logic               ctl_final = 1'b0;
   logic               ctl_clear = 1'b0;
   logic [K*N-1:0]     a_vec = '0;
   logic [K*N-1:0]     b_vec = '0;
   logic               out_valid;
   logic [RW-1:0]      out_row;
   logic [K*ACC_W-1:0] out_vec;

   int          errors = 0;
   int          checks = 0;
   int          edges  = 0;
   int unsigned seed   = 32'h1234_5678;
   string       phase  = "R1";
   bit          done   = 1'b0;

   // Reference state: abstract partial sums plus a schedule of expected rows
   longint             m [K][K];
   bit                 ev [SLOTS];
   int                 er [SLOTS];
   logic [K*ACC_W-1:0] evec [SLOTS];

   always #2.5 clk = ~clk;

   sysmat_engine #(.K(K), .N(N), .OUT_REG(OUT_REG)) u_sysmat_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctl_keep(ctl_keep),
      .ctl_final(ctl_final), .ctl_clear(ctl_clear), .a_vec(a_vec), .b_vec(b_vec),
      .out_valid(out_valid), .out_row(out_row), .out_vec(out_vec)
   );

   initial begin
      for (int s = 0; s < SLOTS; s++) begin ev[s] = 1'b0; er[s] = 0; evec[s] = '0; end
      for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) m[i][j] = 0;
   end

   // Model steps on the same edge the design samples its inputs
   always @(posedge clk) begin
      edges = edges + 1;
      if (!rst_n) begin
         for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) m[i][j] = 0;
      end else begin
         if (ctl_clear)
            for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) m[i][j] = 0;
         if (in_valid) begin
            for (int i = 0; i < K; i++) begin
               for (int j = 0; j < K; j++) begin
                  longint p;
                  p = longint'($signed(a_vec[i*N +: N])) * longint'($signed(b_vec[j*N +: N]));
                  m[i][j] = ctl_keep ? m[i][j] + p : p;
               end
            end
            if (ctl_final) begin
               for (int r = 0; r < K; r++) begin
                  int slot;
                  logic [K*ACC_W-1:0] v;
                  slot = (edges + K + r - 1 + OUT_REG) % SLOTS;
                  for (int j = 0; j < K; j++) v[j*ACC_W +: ACC_W] = m[r][j][ACC_W-1:0];
                  ev[slot]   = 1'b1;
                  er[slot]   = r;
                  evec[slot] = v;
               end
            end
         end
      end
   end

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         int slot;
         slot = edges % SLOTS;
         checks = checks + 1;
         if (ev[slot]) begin
            if (out_valid !== 1'b1 || int'(out_row) != er[slot] || out_vec !== evec[slot]) begin
               errors = errors + 1;
               $display("FAIL %s (R2 R3 R4) edge %0d: valid=%b row=%0d vec=%h expected valid=1 row=%0d vec=%h",
                        phase, edges, out_valid, out_row, out_vec, er[slot], evec[slot]);
            end
         end else if (out_valid !== 1'b0 || out_vec !== '0) begin
            errors = errors + 1;
            $display("FAIL %s (R1 R9) edge %0d: valid=%b vec=%h expected valid=0 vec=0",
                     phase, edges, out_valid, out_vec);
         end
         ev[slot] = 1'b0;
      end
   end

   function automatic logic [N-1:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed[23:16];
   endfunction

   task automatic go_idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0; ctl_keep = 1'b0; ctl_final = 1'b0; ctl_clear = 1'b0;
         for (int l = 0; l < K; l++) begin a_vec[l*N +: N] = rnd(); b_vec[l*N +: N] = rnd(); end
      end
   endtask

   // kind 0: random; 1: both most negative; 2: most negative times most positive
   task automatic job(input int steps, input bit first_keep, input int kind,
                      input bit bubbles, input int restart_at);
      for (int s = 0; s < steps; s++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         ctl_clear = 1'b0;
         ctl_keep  = (s == 0) ? first_keep : (s == restart_at ? 1'b0 : 1'b1);
         ctl_final = (s == steps - 1);
         for (int l = 0; l < K; l++) begin
            case (kind)
               1:       begin a_vec[l*N +: N] = {1'b1, {(N-1){1'b0}}}; b_vec[l*N +: N] = {1'b1, {(N-1){1'b0}}}; end
               2:       begin a_vec[l*N +: N] = {1'b1, {(N-1){1'b0}}}; b_vec[l*N +: N] = {1'b0, {(N-1){1'b1}}}; end
               default: begin a_vec[l*N +: N] = rnd(); b_vec[l*N +: N] = rnd(); end
            endcase
         end
         if (bubbles && s != steps - 1) go_idle(1);
      end
   endtask

   task automatic clear_pulse();
      @(negedge clk);
      in_valid = 1'b0; ctl_keep = 1'b0; ctl_final = 1'b0; ctl_clear = 1'b1;
      go_idle(1);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL R3 watchdog: run reached %0d cycles, expected fewer than 50000", edges);
      summary();
      $finish;
   end

   initial begin
      phase = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      go_idle(4);

      phase = "R2 R4";
      job(K, 1'b0, 0, 1'b0, -1);       go_idle(3*K);
      phase = "R3";
      job(1, 1'b0, 0, 1'b0, -1);       go_idle(3*K);
      job(2*K+1, 1'b0, 0, 1'b0, -1);   go_idle(3*K);

      phase = "R8";
      job(K, 1'b0, 1, 1'b0, -1);       go_idle(3*K);
      job(K, 1'b0, 2, 1'b0, -1);       go_idle(3*K);
      job(K, 1'b1, 1, 1'b0, -1);       go_idle(3*K);

      phase = "R5";
      job(K, 1'b0, 0, 1'b0, -1);
      job(K, 1'b1, 0, 1'b0, -1);       go_idle(3*K);

      phase = "R6";
      job(K+1, 1'b0, 0, 1'b0, 2);      go_idle(3*K);

      phase = "R9";
      job(K+2, 1'b0, 0, 1'b1, -1);     go_idle(3*K);

      phase = "R7";
      job(K, 1'b0, 0, 1'b0, -1);       go_idle(3*K);
      clear_pulse();                   go_idle(2);
      job(K, 1'b1, 0, 1'b0, -1);       go_idle(3*K);

      phase = "R10";
      job(K, 1'b0, 0, 1'b0, -1);
      job(K, 1'b0, 1, 1'b0, -1);
      job(K+1, 1'b0, 0, 1'b0, -1);
      job(K, 1'b1, 2, 1'b0, -1);       go_idle(4*K);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule